// File: doc/BRIEF.md
# Guarded Clock Control Register

This block is a small memory-mapped clock configuration register that refuses writes that would break the safe order of clock changes. It holds four controls: a PLL enable, a two-bit PLL multiplier code, a system clock source select (crystal or PLL) and a RAM clock halving select. Software writes it through a one-cycle valid/address/data strobe. The current settings, a lock indication and a sticky error flag are returned on a readback bus. The field outputs drive the analog PLL, the clock multiplexer and the RAM clock divider, which lie outside this block.

A lock timer runs beside the register. An accepted write that turns the PLL on moves the timer FSM from `LK_IDLE` to `LK_COUNT` and loads a down-counter with `LOCK_CYCLES - 1`. When the counter has reached zero, the FSM moves from `LK_COUNT` to `LK_DONE` and the lock bit reads 1. An accepted write that turns the PLL off moves the FSM back to `LK_IDLE` from either `LK_COUNT` or `LK_DONE`. The switch to the PLL source is allowed only in `LK_DONE`. The `comm_active` input marks periods when the attached communication controller is sending or receiving. During such periods the clock source and the RAM divider must not be moved.

A write that breaks any rule is refused as a whole and sets a sticky error flag. Software clears the flag by writing 1 to it.

Top module: `clk_guard_reg`

## Requirements
- R1: After reset, the readback `rd_data` is 0x0C, `pll_mult` is 2'b11, and `pll_enable`, `sys_src_pll` and `ram_div2` are 0. Readback layout: bit0 PLL on, bit1 source is PLL, bits 3:2 multiplier, bit4 RAM clock halved, bit5 locked, bit6 illegal-write flag, bit7 always 0.
- R2: An accepted write to address 0 loads bits 4:0 of `wr_data` into the fields with the same bit positions. The new value appears on `rd_data` and on the outputs one clock after the write.
- R3: A write to address 0 that changes the multiplier code while the PLL is on is refused.
- R4: A write to address 0 that sets the source bit from 0 to 1 is refused unless the PLL is on and the lock bit is 1.
- R5: The lock bit reads 1 exactly `LOCK_CYCLES` clocks after the accepted write that turned the PLL on, and 0 before then.
- R6: A write to address 0 that turns the PLL off is refused if the source bit is 1, either currently or in the written value. An accepted power-off clears the lock bit one clock after the write.
- R7: While `comm_active` is 1, a write to address 0 that changes the source bit or the RAM halving bit is refused. A write that changes neither of those bits is still accepted.
- R8: A refused write leaves bits 4:0 unchanged and sets the illegal-write flag (bit6). The flag stays set until a write to address 1 with bit6 = 1 clears it. A write to address 1 with bit6 = 0 leaves the flag as it is.
- R9: `sys_src_pll` follows readback bit1, `ram_div2` follows bit4, `pll_enable` follows bit0, and `pll_mult` follows bits 3:2.
- R10: A write to any address other than 0 or 1 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address: 0 = control, 1 = status |
| wr_data | input | 8 | Write data |
| comm_active | input | 1 | Communication controller is transmitting or receiving |
| pll_enable | output | 1 | PLL power-on control |
| pll_mult | output | 2 | Multiplier code: 00 ×20, 01 ×16, 10 ×10, 11 ×8 |
| sys_src_pll | output | 1 | System clock source: 0 crystal, 1 PLL |
| ram_div2 | output | 1 | RAM clock: 0 system clock, 1 system clock divided by 2 |
| rd_data | output | 8 | Readback of the fields, the lock bit and the illegal-write flag |

## Verification
The vector walk takes the register through a full power-up sequence and then a full power-down sequence. Between the legal steps it inserts one illegal write of each kind. Each illegal write is followed at once by a flag-clearing write, so every refusal is seen on its own and a wrong rule shows up as the wrong readback byte. Some patterns differ from a legal write only in whether `comm_active` is high, or only in whether the lock has been reached, so a guard that checks the wrong condition is told apart from one that checks the right one. Directed tests sample the lock bit one clock before and on the clock where it must rise. They also check that a flag write of 0 leaves the sticky flag set.

// File: rtl/clk_guard_pkg.sv
package clk_guard_pkg;

    // Control fields, MSB first: bit4 ram_half, bits3:2 mult, bit1 src_pll, bit0 pll_on
    typedef struct packed {
        logic       ram_half;
        logic [1:0] mult;
        logic       src_pll;
        logic       pll_on;
    } ctrl_t;

    typedef enum logic [1:0] {
        LK_IDLE,
        LK_COUNT,
        LK_DONE
    } lock_state_e;

    localparam logic [1:0]  MULT_RESET  = 2'b11;
    localparam int unsigned BIT_LOCKED  = 5;
    localparam int unsigned BIT_ILLEGAL = 6;
    localparam int unsigned CTRL_ADDR   = 0;
    localparam int unsigned STAT_ADDR   = 1;

endpackage

// File: rtl/clk_guard_lock.sv
module clk_guard_lock
    import clk_guard_pkg::*;
#(
    parameter int unsigned LOCK_CYCLES = 60000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    output logic locked
);

    localparam int unsigned CNT_W = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(LOCK_CYCLES - 1);

    lock_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_IDLE:  if (start) state_d = LK_COUNT;
            LK_COUNT: begin
                if (stop)              state_d = LK_IDLE;
                else if (cnt_q == '0)  state_d = LK_DONE;
            end
            LK_DONE:  if (stop) state_d = LK_IDLE;
            default:  state_d = LK_IDLE;
        endcase
    end

    // Down-counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   cnt_q <= '0;
        else if (start)                               cnt_q <= LOAD_VAL;
        else if (state_q == LK_COUNT && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    // Outputs
    always_comb begin
        locked = (state_q == LK_DONE);
    end

    p_start_unlocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !locked);

    p_stop_unlocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !locked);

endmodule

// File: rtl/clk_guard_rules.sv
module clk_guard_rules
    import clk_guard_pkg::*;
(
    input  ctrl_t cur,
    input  ctrl_t nxt,
    input  logic  locked,
    input  logic  comm_active,
    output logic  refuse
);

    logic mult_chg, src_rise, on_fall;
    logic bad_mult, bad_src, bad_off, bad_comm;

    always_comb begin
        mult_chg = (nxt.mult != cur.mult);
        src_rise = nxt.src_pll && !cur.src_pll;
        on_fall  = cur.pll_on && !nxt.pll_on;

        bad_mult = mult_chg && cur.pll_on;                      // R3
        bad_src  = src_rise && !(cur.pll_on && locked);         // R4
        bad_off  = on_fall && (cur.src_pll || nxt.src_pll);     // R6
        bad_comm = comm_active &&
                   ((nxt.ram_half != cur.ram_half) ||
                    (nxt.src_pll  != cur.src_pll));             // R7

        refuse = bad_mult || bad_src || bad_off || bad_comm;
    end

endmodule

// File: rtl/clk_guard_reg.sv
module clk_guard_reg
    import clk_guard_pkg::*;
#(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned LOCK_CYCLES = 60000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              comm_active,
    output logic              pll_enable,
    output logic [1:0]        pll_mult,
    output logic              sys_src_pll,
    output logic              ram_div2,
    output logic [7:0]        rd_data
);

    localparam ctrl_t CTRL_RESET = '{ram_half: 1'b0, mult: MULT_RESET,
                                     src_pll: 1'b0, pll_on: 1'b0};

    ctrl_t cur_q, wr_val;
    logic  illegal_q, locked;
    logic  ctrl_wr, stat_wr, refuse, accept, reject, start, stop;
    logic  unused_wr_bits;

    always_comb begin
        ctrl_wr = wr_valid && (wr_addr == ADDR_W'(CTRL_ADDR));
        stat_wr = wr_valid && (wr_addr == ADDR_W'(STAT_ADDR));
        wr_val  = ctrl_t'(wr_data[4:0]);
        accept  = ctrl_wr && !refuse;
        reject  = ctrl_wr && refuse;
        start   = accept && wr_val.pll_on && !cur_q.pll_on;
        stop    = accept && !wr_val.pll_on && cur_q.pll_on;
    end

    assign unused_wr_bits = ^{wr_data[7], wr_data[5]};

    clk_guard_rules u_rules (
        .cur         (cur_q),
        .nxt         (wr_val),
        .locked      (locked),
        .comm_active (comm_active),
        .refuse      (refuse)
    );

    clk_guard_lock #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .stop   (stop),
        .locked (locked)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cur_q <= CTRL_RESET;
        else if (accept) cur_q <= wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             illegal_q <= 1'b0;
        else if (reject)                        illegal_q <= 1'b1;
        else if (stat_wr && wr_data[BIT_ILLEGAL]) illegal_q <= 1'b0;
    end

    always_comb begin
        pll_enable  = cur_q.pll_on;
        pll_mult    = cur_q.mult;
        sys_src_pll = cur_q.src_pll;
        ram_div2    = cur_q.ram_half;
        rd_data     = {1'b0, illegal_q, locked, cur_q};
    end

    p_src_needs_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sys_src_pll |-> (pll_enable && locked));

    p_mult_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pll_enable |=> $stable(pll_mult));

    p_lock_needs_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> pll_enable);

    p_comm_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (comm_active && ctrl_wr) |=> ($stable(ram_div2) && $stable(sys_src_pll)));

    p_refused_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> ($stable(rd_data[4:0]) && rd_data[BIT_ILLEGAL]));

endmodule

// File: tb/clk_guard_reg_test.sv
module clk_guard_reg_test;

    localparam int unsigned ADDR_W = 4;
    localparam int unsigned LOCK   = 20;

    typedef struct packed {
        logic [3:0] a;
        logic [7:0] d;
        logic       c;
        logic [7:0] w;
        logic [7:0] e;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{4'd0, 8'h0C, 1'b0, 8'd0,  8'h0C},  // R2 plain write
        '{4'd0, 8'h00, 1'b0, 8'd0,  8'h00},  // R2 mult change, PLL off
        '{4'd0, 8'h10, 1'b0, 8'd0,  8'h10},  // R2 RAM halved
        '{4'd0, 8'h12, 1'b0, 8'd0,  8'h50},  // R4 source without PLL
        '{4'd1, 8'h40, 1'b0, 8'd0,  8'h10},  // R8 clear flag
        '{4'd0, 8'h11, 1'b0, 8'd0,  8'h11},  // R2 PLL on
        '{4'd0, 8'h15, 1'b0, 8'd0,  8'h51},  // R3 mult change while on
        '{4'd1, 8'h40, 1'b0, 8'd0,  8'h11},  // R8 clear
        '{4'd0, 8'h13, 1'b0, 8'd0,  8'h51},  // R4 source before lock
        '{4'd1, 8'h40, 1'b0, 8'd20, 8'h31},  // R5 locked after wait
        '{4'd0, 8'h13, 1'b0, 8'd0,  8'h33},  // R4 source after lock
        '{4'd0, 8'h10, 1'b0, 8'd0,  8'h73},  // R6 power off while on PLL
        '{4'd1, 8'h40, 1'b0, 8'd0,  8'h33},  // R8 clear
        '{4'd0, 8'h11, 1'b0, 8'd0,  8'h31},  // R2 back to crystal
        '{4'd0, 8'h10, 1'b0, 8'd0,  8'h10},  // R6 power off, lock clears
        '{4'd0, 8'h00, 1'b1, 8'd0,  8'h50},  // R7 RAM change while active
        '{4'd1, 8'h40, 1'b1, 8'd0,  8'h10},  // R8 clear
        '{4'd0, 8'h18, 1'b1, 8'd0,  8'h18},  // R7 mult change while active ok
        '{4'd5, 8'hFF, 1'b0, 8'd0,  8'h18},  // R10 other address
        '{4'd1, 8'h00, 1'b0, 8'd0,  8'h18}   // R8 zero write to status
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_valid = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic              comm_active = 1'b0;
    logic              pll_enable, sys_src_pll, ram_div2;
    logic [1:0]        pll_mult;
    logic [7:0]        rd_data;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    clk_guard_reg #(.ADDR_W(ADDR_W), .LOCK_CYCLES(LOCK)) uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .comm_active(comm_active), .pll_enable(pll_enable),
        .pll_mult(pll_mult), .sys_src_pll(sys_src_pll), .ram_div2(ram_div2),
        .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write(input logic [3:0] a, input logic [7:0] d, input logic c);
        @(negedge clk);
        wr_valid    = 1'b1;
        wr_addr     = a;
        wr_data     = d;
        comm_active = c;
        @(negedge clk);
        wr_valid    = 1'b0;
    endtask

    task automatic check_pins(input string req, input logic [7:0] exp);
        check(req, {4'd0, ram_div2, pll_mult, sys_src_pll}, {4'd0, exp[4:1]});
        check(req, {7'd0, pll_enable}, {7'd0, exp[0]});
    endtask

    initial begin
        #1_000_000;
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset readback", rd_data, 8'h0C);
        check_pins("R1 reset pins", 8'h0C);

        for (int i = 0; i < NV; i++) begin
            write(VECS[i].a, VECS[i].d, VECS[i].c);
            repeat (int'(VECS[i].w)) @(negedge clk);
            check($sformatf("R2/R3/R4/R6/R7/R8/R10 vector %0d", i), rd_data, VECS[i].e);
        end
        check_pins("R9 pins after table", 8'h18);
        comm_active = 1'b0;

        // Reset again, then lock timing boundary
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 second reset", rd_data, 8'h0C);
        write(4'd0, 8'h0D, 1'b0);
        check("R5 locked at write+0", rd_data, 8'h0D);
        repeat (LOCK - 1) @(negedge clk);
        check("R5 locked one short", rd_data, 8'h0D);
        @(negedge clk);
        check("R5 locked exact", rd_data, 8'h2D);

        write(4'd0, 8'h1F, 1'b0);
        check("R2 source to PLL", rd_data, 8'h3F);
        check_pins("R9 pins on PLL", 8'h1F);

        write(4'd0, 8'h1E, 1'b0);
        check("R6 off with source kept", rd_data, 8'h7F);
        write(4'd1, 8'h00, 1'b0);
        check("R8 sticky flag", rd_data, 8'h7F);
        write(4'd1, 8'h40, 1'b0);
        check("R8 flag cleared", rd_data, 8'h3F);

        write(4'd0, 8'h0F, 1'b1);
        check("R7 source change refused when active", rd_data, 8'h7F);
        check_pins("R7 pins held", 8'h1F);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule